// File: doc/BRIEF.md
# Configurable External Interrupt Pin Detector

This block watches a single external interrupt pin and raises a request flag when the pin shows the waveform that software has chosen as valid. A 4-bit control word, written and read through a plain register port, decides whether the pin is looked at, whether low or high is the active sense, whether only the active edge or every edge counts, and whether a real pin edge also fires a one-cycle start pulse towards a companion timer. The pin passes through a synchronizer before any edge is judged.

The request flag is held until it is consumed. With the interrupt-enable input high, the flag drives the interrupt line and is cleared by acceptance. With it low, the flag is left for polled software: a skip-test strobe reports the flag and clears it in the same access. A separate level output lets polled code read whether the pin currently sits at the active level. Because the valid signal is formed from the control word and the pin together, a control write that flips the active sense or switches the pin on can make the formed signal look as if an edge had occurred, and the flag then sets; software is expected to clear it after such a write. While the retention indication is high, the control word keeps its contents and ignores writes.

Top module: `ext_pin_detector`

## Requirements
- R1: After reset the control word reads 0000 and req_flag_o, irq_o, skip_o, timer_start_o and level_o are all 0.
- R2: With the enable bit (bit 3 of the control word) at 0, no pin activity sets the request flag and level_o stays 0.
- R3: With enable 1 and bit 1 at 0, only the edge chosen by bit 2 sets the flag (bit 2 = 0: falling, bit 2 = 1: rising); the flag is 1 three clock edges after the pin changes ahead of the first of them, and the opposite edge does not set it.
- R4: With enable 1 and bit 1 at 1, both rising and falling pin edges set the flag with the same three-edge latency.
- R5: With bit 0 at 1, a real pin edge that sets the flag gives a one-cycle timer_start_o pulse in the same cycle the flag rises; with bit 0 at 0, or when the flag is set by a control write, there is no pulse.
- R6: While enabled, a control write that makes the formed valid signal rise (single-edge mode) or change (both-edge mode), with the pin steady, sets the flag one edge after the write edge.
- R7: While retain_i is 1, control writes are ignored and the read value is unchanged.
- R8: irq_o equals req_flag_o when irq_en_i is 1 and is 0 otherwise; skip_o is 1 only while skip_test_i is 1, irq_en_i is 0 and the flag is set.
- R9: irq_ack_i, or skip_test_i while irq_en_i is 0, clears the flag at the next edge, unless a new qualifying event occurs at that same edge, which keeps it set; skip_test_i with irq_en_i at 1 leaves the flag alone.
- R10: level_o is 1 when enabled and the synchronized pin equals bit 2 (0 = low active, 1 = high active), otherwise 0; it follows the pin two edges after a change.
- R11: cfg_rd_data_o returns the stored control word, bit 3 enable, bit 2 active sense, bit 1 both-edge mode, bit 0 timer start, updated at the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retain_i | input | 1 | Retention indication; blocks control writes |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| cfg_wr_en_i | input | 1 | Control word write strobe |
| cfg_wr_data_i | input | 4 | Control word write data |
| cfg_rd_data_o | output | 4 | Stored control word |
| irq_en_i | input | 1 | Interrupt enable for this source |
| irq_ack_i | input | 1 | Interrupt acceptance, clears the flag |
| skip_test_i | input | 1 | Skip-test read strobe |
| req_flag_o | output | 1 | Request flag |
| irq_o | output | 1 | Interrupt request to the vectoring logic |
| skip_o | output | 1 | Skip-test result |
| timer_start_o | output | 1 | One-cycle timer count-start pulse |
| level_o | output | 1 | Level-test result |

## Verification
A pin change made before clock edge one shows in level_o after edge two and in req_flag_o and timer_start_o after edge three; a control write shows in the read value after its own edge and in the flag one edge later; irq_o and skip_o follow their inputs in the same cycle. The bench drives every input one time unit after a rising edge, advances a cycle-accurate model of those register stages in step with each edge, and compares all outputs one unit after the edge, so each check lands in the cycle where the result is due. Directed cases pin the latencies down with constant expected values, and a seeded random run covers mixed writes, retention, clears and pin activity.

// File: rtl/ext_pin_pkg.sv
package ext_pin_pkg;
  localparam int CFG_W = 4;

  // Packed order gives bit 3 = enable ... bit 0 = timer start.
  typedef struct packed {
    logic enable;
    logic pol_high;
    logic both_edges;
    logic timer_sync;
  } pin_cfg_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[LAST];
endmodule

// File: rtl/pin_cfg_reg.sv
module pin_cfg_reg
  import ext_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retain_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output pin_cfg_t         cfg_o,
  output logic [CFG_W-1:0] rd_data_o
);
  pin_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cfg_q <= '0;
    else if (wr_en_i && !retain_i) cfg_q <= pin_cfg_t'(wr_data_i);
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = cfg_q;

  // R7: retention freezes the control word
  p_retain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retain_i |=> $stable(rd_data_o));
endmodule

// File: rtl/edge_qualifier.sv
module edge_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic enable_i,
  input  logic pol_high_i,
  input  logic both_edges_i,
  output logic event_o,
  output logic real_edge_o,
  output logic level_o
);
  logic q_prev;
  logic s_prev;
  logic qual;
  logic rise;
  logic change;

  // Formed valid signal: active sense applied, gated by enable.
  assign qual   = enable_i & (pol_high_i ? sync_i : ~sync_i);
  assign rise   = qual & ~q_prev;
  assign change = qual ^ q_prev;

  always_comb begin
    if (!enable_i)         event_o = 1'b0;
    else if (both_edges_i) event_o = change;
    else                   event_o = rise;
  end

  assign real_edge_o = event_o & (sync_i ^ s_prev);
  assign level_o     = qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_prev <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      q_prev <= qual;
      s_prev <= sync_i;
    end
  end

  // R3: a single-edge event cannot repeat on the next cycle
  p_single_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && !both_edges_i) |=> !(event_o && !both_edges_i));
  // R10: level test is off while the pin is disabled
  p_level_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !level_o);
endmodule

// File: rtl/req_flag_ctrl.sv
module req_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic real_edge_i,
  input  logic timer_sync_i,
  input  logic irq_en_i,
  input  logic irq_ack_i,
  input  logic skip_test_i,
  output logic flag_o,
  output logic timer_start_o,
  output logic irq_o,
  output logic skip_o
);
  logic flag_q;
  logic timer_q;
  logic clr;

  assign clr = irq_ack_i | (skip_test_i & ~irq_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      timer_q <= 1'b0;
    end else begin
      // a new event wins over a clear at the same edge
      flag_q  <= event_i | (flag_q & ~clr);
      timer_q <= real_edge_i & timer_sync_i;
    end
  end

  assign flag_o        = flag_q;
  assign timer_start_o = timer_q;
  assign irq_o         = flag_q & irq_en_i;
  assign skip_o        = flag_q & skip_test_i & ~irq_en_i;

  // R5: timer pulse only alongside a set flag
  p_timer_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start_o |-> flag_o);
  // R8: interrupt and skip never report together
  p_skip_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_o && irq_o));
  // R9: clear without a competing event empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !event_i) |=> !flag_o);
endmodule

// File: rtl/ext_pin_detector.sv
module ext_pin_detector
  import ext_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retain_i,
  input  logic             pin_i,
  input  logic             cfg_wr_en_i,
  input  logic [CFG_W-1:0] cfg_wr_data_i,
  output logic [CFG_W-1:0] cfg_rd_data_o,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  input  logic             skip_test_i,
  output logic             req_flag_o,
  output logic             irq_o,
  output logic             skip_o,
  output logic             timer_start_o,
  output logic             level_o
);
  pin_cfg_t cfg;
  logic     pin_s;
  logic     evt;
  logic     real_edge;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  pin_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .retain_i  (retain_i),
    .wr_en_i   (cfg_wr_en_i),
    .wr_data_i (cfg_wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (cfg_rd_data_o)
  );

  edge_qualifier u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (pin_s),
    .enable_i     (cfg.enable),
    .pol_high_i   (cfg.pol_high),
    .both_edges_i (cfg.both_edges),
    .event_o      (evt),
    .real_edge_o  (real_edge),
    .level_o      (level_o)
  );

  req_flag_ctrl u_flag (
    .clk           (clk),
    .rst_n         (rst_n),
    .event_i       (evt),
    .real_edge_i   (real_edge),
    .timer_sync_i  (cfg.timer_sync),
    .irq_en_i      (irq_en_i),
    .irq_ack_i     (irq_ack_i),
    .skip_test_i   (skip_test_i),
    .flag_o        (req_flag_o),
    .timer_start_o (timer_start_o),
    .irq_o         (irq_o),
    .skip_o        (skip_o)
  );

  // R2: the flag can only rise while the pin was enabled
  p_flag_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag_o) |-> $past(cfg.enable));
  // R5: a timer pulse needs the start bit set the cycle before
  p_timer_needs_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start_o |-> $past(cfg.timer_sync));
endmodule

// File: tb/ext_pin_detector_tb_top.sv
module ext_pin_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retain_i = 1'b0;
  logic       pin_i = 1'b0;
  logic       cfg_wr_en_i = 1'b0;
  logic [3:0] cfg_wr_data_i = 4'd0;
  logic [3:0] cfg_rd_data_o;
  logic       irq_en_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       skip_test_i = 1'b0;
  logic       req_flag_o, irq_o, skip_o, timer_start_o, level_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic       m_s1 = 0, m_s2 = 0, m_sp = 0, m_qp = 0, m_flag = 0, m_timer = 0;
  logic [3:0] m_cfg = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_pin_detector dut_i (
    .clk(clk), .rst_n(rst_n), .retain_i(retain_i), .pin_i(pin_i),
    .cfg_wr_en_i(cfg_wr_en_i), .cfg_wr_data_i(cfg_wr_data_i),
    .cfg_rd_data_o(cfg_rd_data_o), .irq_en_i(irq_en_i),
    .irq_ack_i(irq_ack_i), .skip_test_i(skip_test_i),
    .req_flag_o(req_flag_o), .irq_o(irq_o), .skip_o(skip_o),
    .timer_start_o(timer_start_o), .level_o(level_o)
  );

  function automatic logic f_qual(logic [3:0] c, logic s);
    return c[3] & (c[2] ? s : ~s);
  endfunction

  function automatic logic f_event(logic [3:0] c, logic s, logic qp);
    logic q;
    q = f_qual(c, s);
    if (!c[3]) return 1'b0;
    return c[1] ? (q ^ qp) : (q & ~qp);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R9 flag", {3'b0, req_flag_o}, {3'b0, m_flag});
    chk("R5 timer", {3'b0, timer_start_o}, {3'b0, m_timer});
    chk("R11 readback", cfg_rd_data_o, m_cfg);
    chk("R10 level", {3'b0, level_o}, {3'b0, f_qual(m_cfg, m_s2)});
    chk("R8 irq", {3'b0, irq_o}, {3'b0, m_flag & irq_en_i});
    chk("R8 skip", {3'b0, skip_o}, {3'b0, m_flag & skip_test_i & ~irq_en_i});
  endtask

  // one clock edge: advance model with the inputs in force, then compare
  task automatic step();
    logic ev, rl, q, clr;
    q   = f_qual(m_cfg, m_s2);
    ev  = f_event(m_cfg, m_s2, m_qp);
    rl  = ev & (m_s2 ^ m_sp);
    clr = irq_ack_i | (skip_test_i & ~irq_en_i);
    @(posedge clk);
    #1;
    m_flag  = ev | (m_flag & ~clr);
    m_timer = rl & m_cfg[0];
    m_qp    = q;
    m_sp    = m_s2;
    m_s2    = m_s1;
    m_s1    = pin_i;
    if (cfg_wr_en_i && !retain_i) m_cfg = cfg_wr_data_i;
    check_all();
  endtask

  task automatic wr(input logic [3:0] d);
    cfg_wr_en_i = 1'b1; cfg_wr_data_i = d;
    step();
    cfg_wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_flag();
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 cfg", cfg_rd_data_o, 4'b0000);
    chk("R1 outs", {req_flag_o, irq_o, skip_o, timer_start_o}, 4'b0000);
    chk("R1 level", {3'b0, level_o}, 4'b0000);
    rst_n = 1'b1;
    idle(2);

    // R11: readback with bit positions
    wr(4'b0110);
    chk("R11 written", cfg_rd_data_o, 4'b0110);

    // R2: disabled pin ignored
    wr(4'b0100);
    for (int i = 0; i < 6; i++) begin pin_i = ~pin_i; step(); end
    idle(3);
    chk("R2 no flag", {3'b0, req_flag_o}, 4'b0000);
    chk("R2 no level", {3'b0, level_o}, 4'b0000);

    // R3: falling single edge, latency three edges
    pin_i = 1'b1; idle(4);
    wr(4'b1000); clear_flag();
    pin_i = 1'b0;
    step(); chk("R3 edge1", {3'b0, req_flag_o}, 4'b0000);
    step(); chk("R3 edge2", {3'b0, req_flag_o}, 4'b0000);
    chk("R10 low active", {3'b0, level_o}, 4'b0001);
    step(); chk("R3 edge3", {3'b0, req_flag_o}, 4'b0001);
    clear_flag();
    chk("R9 ack clears", {3'b0, req_flag_o}, 4'b0000);
    pin_i = 1'b1; idle(4);
    chk("R3 opposite edge", {3'b0, req_flag_o}, 4'b0000);

    // R6: write flips sense with pin steady high
    wr(4'b1100);
    chk("R6 write edge", {3'b0, req_flag_o}, 4'b0000);
    step();
    chk("R6 set after write", {3'b0, req_flag_o}, 4'b0001);
    chk("R5 no pulse on write", {3'b0, timer_start_o}, 4'b0000);
    clear_flag();

    // R5: timer pulse on real falling edge
    wr(4'b1001); clear_flag();
    pin_i = 1'b0; idle(2);
    step();
    chk("R5 pulse", {timer_start_o, req_flag_o}, 4'b0011);
    step();
    chk("R5 pulse ends", {3'b0, timer_start_o}, 4'b0000);

    // R8 / R9: skip test behaviour
    irq_en_i = 1'b1; skip_test_i = 1'b1; #1;
    chk("R8 skip blocked", {skip_o, irq_o}, 4'b0001);
    step(); chk("R9 skip kept", {3'b0, req_flag_o}, 4'b0001);
    irq_en_i = 1'b0; #1;
    chk("R8 skip reports", {skip_o, irq_o}, 4'b0010);
    step(); skip_test_i = 1'b0;
    chk("R9 skip clears", {3'b0, req_flag_o}, 4'b0000);

    // R4: both edges
    wr(4'b1010); clear_flag();
    pin_i = 1'b1; idle(3);
    chk("R4 rising", {3'b0, req_flag_o}, 4'b0001);
    clear_flag();
    pin_i = 1'b0; idle(3);
    chk("R4 falling", {3'b0, req_flag_o}, 4'b0001);

    // R7: retention blocks writes
    retain_i = 1'b1;
    wr(4'b0101);
    chk("R7 held", cfg_rd_data_o, 4'b1010);
    retain_i = 1'b0;

    // R9: event at the same edge as a clear keeps the flag
    clear_flag();
    pin_i = 1'b1; idle(2);
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
    chk("R9 set wins", {3'b0, req_flag_o}, 4'b0001);

    // random phase
    for (int n = 0; n < RAND_CYCLES; n++) begin
      if ($urandom_range(3) == 0) pin_i = ~pin_i;
      cfg_wr_en_i   = ($urandom_range(11) == 0);
      cfg_wr_data_i = 4'($urandom_range(15));
      retain_i      = ($urandom_range(5) == 0);
      irq_ack_i     = ($urandom_range(9) == 0);
      skip_test_i   = ($urandom_range(7) == 0);
      if ($urandom_range(31) == 0) irq_en_i = ~irq_en_i;
      step();
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule